// File: doc/BRIEF.md
# CAN Bus Dominant-Lock Detector

This block watches the sampled bit stream of a CAN bus and reports when the bus has been held dominant for too long. An external bit-timing unit supplies the sampled bit value and a strobe that marks each sample point. While the node is in operation mode, the block counts consecutive dominant samples. When a run reaches the threshold, it raises a sticky lock flag and emits a one-cycle detect pulse.

Software clears the flag with a single-cycle clear input. Clearing the flag does not make the detector live again at once. Detection re-arms only after one of two things happens. Either a recessive sample is seen in operation mode, which shows the lock has resolved. Or the node passes through reset mode and then returns to operation mode. Until then, a lock that persists cannot raise the flag a second time.

Top module: `bus_lock_detect`

## Requirements
- R1: With `mode_i` = 2'b00 (operation), the flag `lock_o` rises on the clock edge that registers the 32nd consecutive dominant sample (`bit_i` = 0 with `sample_i` = 1). Cycles without `sample_i` are neither counted nor break the run.
- R2: A recessive sample (`bit_i` = 1 with `sample_i` = 1) restarts the run, so 31 further dominant samples leave the flag low.
- R3: Samples are counted only in operation mode. The other encodings are 2'b01 reset, 2'b10 halt and 2'b11 sleep. Leaving operation mode discards the run counted so far.
- R4: Once set, the flag stays set until `clr_i` is asserted, including while the node is outside operation mode. A `clr_i` cycle while the flag is set clears it on the next edge.
- R5: `lock_pulse_o` is high for exactly one cycle, in the same cycle the flag first reads 1. Dominant samples that continue past the threshold do not repeat it.
- R6: After a clear, detection stays disarmed. A dominant run of any length leaves the flag low. A recessive sample seen while the flag was still set does not count toward re-arming.
- R7: After a clear, one recessive sample in operation mode re-arms detection. A fresh run of 32 dominant samples then sets the flag again.
- R8: After a clear, entering reset mode and then returning to operation mode re-arms detection. Passing through halt or sleep mode instead does not re-arm it.
- R9: If `clr_i` is asserted in the cycle that registers the 32nd dominant sample, the detection wins: the flag reads 1 and the pulse fires.
- R10: After `rst_ni` is asserted, `lock_o` and `lock_pulse_o` are 0 and detection is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Sampled bus level, 0 = dominant, 1 = recessive |
| sample_i | input | 1 | High in each cycle that holds a valid bus sample |
| mode_i | input | 2 | Node mode: 00 operation, 01 reset, 10 halt, 11 sleep |
| clr_i | input | 1 | Software clear of the lock flag |
| lock_o | output | 1 | Sticky bus-lock flag |
| lock_pulse_o | output | 1 | One-cycle pulse when the flag rises |

## Verification
The bench sweeps uninterrupted dominant runs of every length from 0 to 40 samples. This separates runs that stop short of the threshold, runs that land exactly on it, and runs that overshoot it, where exactly one pulse must appear. A second sweep places a single recessive sample after every possible prefix length from 0 to 31 and then checks the 31st and 32nd dominant samples that follow, which shows the restart position precisely. Directed sequences then compare the two re-arm paths with non-arming paths: a recessive sample taken before the clear, and a detour through halt or sleep mode. Further sequences cover mode gating in the middle of a run, runs with gaps between strobes, and a clear that coincides with a detection.

// File: rtl/bus_lock_pkg.sv
package bus_lock_pkg;

  typedef enum logic [1:0] {
    MODE_OPER  = 2'b00,
    MODE_RESET = 2'b01,
    MODE_HALT  = 2'b10,
    MODE_SLEEP = 2'b11
  } op_mode_e;

  typedef enum logic [1:0] {
    ARM_READY,
    ARM_HELD,
    ARM_WAIT,
    ARM_WAIT_RST
  } arm_state_e;

endpackage

// File: rtl/dom_run_counter.sv
module dom_run_counter #(
  parameter int unsigned RUN_LEN = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oper_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic hit_o,
  output logic rec_o
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(RUN_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(RUN_LEN - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!oper_i) begin
      cnt_q <= '0;
    end else if (sample_i) begin
      if (bit_i)                 cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;  // saturate, no wrap
    end
  end

  // this strobe completes the run
  assign hit_o = oper_i & sample_i & ~bit_i & (cnt_q == CNT_LAST);
  assign rec_o = oper_i & sample_i & bit_i;

endmodule

// File: rtl/lock_arm_fsm.sv
module lock_arm_fsm
  import bus_lock_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     det_i,
  input  logic     clr_i,
  input  logic     rec_i,
  input  op_mode_e mode_i,
  output logic     armed_o
);
  arm_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ARM_READY:    if (det_i) st_d = ARM_HELD;
      ARM_HELD:     if (clr_i) st_d = ARM_WAIT;
      ARM_WAIT: begin
        if (rec_i)                    st_d = ARM_READY;
        else if (mode_i == MODE_RESET) st_d = ARM_WAIT_RST;
      end
      ARM_WAIT_RST: if (mode_i == MODE_OPER) st_d = ARM_READY;
      default:      st_d = ARM_READY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ARM_READY;
    else         st_q <= st_d;
  end

  assign armed_o = (st_q == ARM_READY);

endmodule

// File: rtl/lock_flag_reg.sv
module lock_flag_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic det_i,
  input  logic clr_i,
  output logic lock_o,
  output logic pulse_o
);
  logic lock_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= det_i & ~lock_q;
      if (det_i)      lock_q <= 1'b1;  // detection beats clear
      else if (clr_i) lock_q <= 1'b0;
    end
  end

  assign lock_o  = lock_q;
  assign pulse_o = pulse_q;

endmodule

// File: rtl/bus_lock_detect.sv
module bus_lock_detect
  import bus_lock_pkg::*;
#(
  parameter int unsigned RUN_LEN = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       sample_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       lock_o,
  output logic       lock_pulse_o
);
  op_mode_e mode;
  logic     oper, hit, rec, armed, det;

  assign mode = op_mode_e'(mode_i);
  assign oper = (mode == MODE_OPER);
  assign det  = hit & armed;

  dom_run_counter #(.RUN_LEN(RUN_LEN)) i_run (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .oper_i   (oper),
    .sample_i (sample_i),
    .bit_i    (bit_i),
    .hit_o    (hit),
    .rec_o    (rec)
  );

  lock_arm_fsm i_arm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .det_i   (det),
    .clr_i   (clr_i),
    .rec_i   (rec),
    .mode_i  (mode),
    .armed_o (armed)
  );

  lock_flag_reg i_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .det_i   (det),
    .clr_i   (clr_i),
    .lock_o  (lock_o),
    .pulse_o (lock_pulse_o)
  );

endmodule

// File: rtl/bus_lock_detect_chk.sv
module bus_lock_detect_chk #(
  parameter int unsigned RUN_LEN = 32
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bit_i,
  input logic       sample_i,
  input logic [1:0] mode_i,
  input logic       clr_i,
  input logic       lock_o,
  input logic       lock_pulse_o
);
  // independent run tracker, saturating
  logic [6:0] run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_q <= '0;
    else if (mode_i != 2'b00)          run_q <= '0;
    else if (sample_i && bit_i)        run_q <= '0;
    else if (sample_i && run_q != 7'h7f) run_q <= run_q + 1'b1;
  end

  a_r1_rise_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> (32'(run_q) >= RUN_LEN));

  a_r2_recessive_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && bit_i) |=> !lock_pulse_o);

  a_r3_idle_mode_no_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i != 2'b00) |=> !$rose(lock_o));

  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !clr_i) |=> lock_o);

  a_r5_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_pulse_o |-> (lock_o && !$past(lock_o)));

  a_r5_rise_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> lock_pulse_o);

endmodule

bind bus_lock_detect bus_lock_detect_chk #(.RUN_LEN(RUN_LEN)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_i        (bit_i),
  .sample_i     (sample_i),
  .mode_i       (mode_i),
  .clr_i        (clr_i),
  .lock_o       (lock_o),
  .lock_pulse_o (lock_pulse_o)
);

// File: tb/test_bus_lock_detect.sv
module test_bus_lock_detect;
  localparam logic [1:0] M_OPER = 2'b00, M_RST = 2'b01, M_HALT = 2'b10, M_SLEEP = 2'b11;
  localparam int THR = 32;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_v = 1'b1;
  logic       smp = 1'b0;
  logic [1:0] mode = M_OPER;
  logic       clr = 1'b0;
  logic       lock, pulse;

  int total = 0;
  int bad = 0;
  int pcount = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  bus_lock_detect i_bus_lock_detect (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(bit_v), .sample_i(smp),
    .mode_i(mode), .clr_i(clr), .lock_o(lock), .lock_pulse_o(pulse)
  );

  always @(posedge clk) begin
    #2;
    if (rst_n && pulse) pcount++;
  end

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic bits(input logic b, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_v = b; smp = 1'b1;
      @(negedge clk); smp = 1'b0;
    end
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); mode = m;
    @(negedge clk);
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic rearm();
    do_clr();
    set_mode(M_RST);
    set_mode(M_OPER);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    chk("R10 lock in reset", lock, 0);
    chk("R10 pulse in reset", pulse, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R10: armed from reset
    p0 = pcount;
    bits(1'b0, THR);
    chk("R10 armed after reset", lock, 1);
    chk("R5 single pulse", pcount - p0, 1);

    // R1/R5 sweep of run lengths
    for (int n = 0; n <= 40; n++) begin
      rearm();
      p0 = pcount;
      bits(1'b0, n);
      chk("R1 run sweep flag", lock, (n >= THR) ? 1 : 0);
      chk("R5 run sweep pulses", pcount - p0, (n >= THR) ? 1 : 0);
    end

    // R2 restart at every position
    for (int k = 0; k < THR; k++) begin
      rearm();
      bits(1'b0, k);
      bits(1'b1, 1);
      bits(1'b0, THR - 1);
      chk("R2 after restart 31", lock, 0);
      bits(1'b0, 1);
      chk("R2 after restart 32", lock, 1);
    end

    // R1: gaps without strobe ignored
    rearm();
    bits(1'b0, 20);
    @(negedge clk); bit_v = 1'b1; smp = 1'b0;
    repeat (10) @(negedge clk);
    bits(1'b0, 11);
    chk("R1 gap ignored 31", lock, 0);
    bits(1'b0, 1);
    chk("R1 gap ignored 32", lock, 1);

    // R3 mode gating
    rearm();
    set_mode(M_HALT);
    bits(1'b0, 40);
    chk("R3 halt no count", lock, 0);
    set_mode(M_SLEEP);
    bits(1'b0, 40);
    chk("R3 sleep no count", lock, 0);
    set_mode(M_OPER);
    bits(1'b0, 20);
    set_mode(M_HALT);
    set_mode(M_OPER);
    bits(1'b0, 20);
    chk("R3 run discarded", lock, 0);
    bits(1'b0, 12);
    chk("R3 fresh run", lock, 1);

    // R4 sticky
    set_mode(M_RST);
    chk("R4 held in reset mode", lock, 1);
    set_mode(M_OPER);
    bits(1'b1, 5);
    repeat (50) @(negedge clk);
    chk("R4 held idle", lock, 1);
    do_clr();
    chk("R4 cleared", lock, 0);

    // R6 disarmed after clear
    rearm();
    bits(1'b0, THR);
    bits(1'b1, 3);          // recessive before clear
    do_clr();
    p0 = pcount;
    bits(1'b0, 80);
    chk("R6 disarmed flag", lock, 0);
    chk("R6 disarmed pulse", pcount - p0, 0);

    // R7 re-arm by recessive
    bits(1'b1, 1);
    bits(1'b0, THR - 1);
    chk("R7 rearm 31", lock, 0);
    bits(1'b0, 1);
    chk("R7 rearm 32", lock, 1);

    // R8 halt/sleep do not re-arm, reset does
    do_clr();
    set_mode(M_HALT);
    set_mode(M_SLEEP);
    set_mode(M_OPER);
    bits(1'b0, 40);
    chk("R8 halt sleep no rearm", lock, 0);
    set_mode(M_RST);
    set_mode(M_OPER);
    bits(1'b0, THR - 1);
    chk("R8 reset rearm 31", lock, 0);
    p0 = pcount;
    bits(1'b0, 1);
    chk("R8 reset rearm 32", lock, 1);
    chk("R8 reset rearm pulse", pcount - p0, 1);

    // R9 clear coincides with detection
    rearm();
    bits(1'b0, THR - 1);
    p0 = pcount;
    @(negedge clk); bit_v = 1'b0; smp = 1'b1; clr = 1'b1;
    @(negedge clk); smp = 1'b0; clr = 1'b0;
    chk("R9 detect wins flag", lock, 1);
    chk("R9 detect wins pulse", pcount - p0, 1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule